// File: doc/BRIEF.md
# Keyboard-Adjustable Square Wave Source

This block turns a free-running tick counter into a square wave expressed as a stream of 12-bit codes for a digital-to-analog converter. Every period consists of a low half, where the code is zero, followed by a high half, where the code equals an adjustable amplitude. Both halves last the same programmable number of clock ticks. A write strobe accompanies every change of level, so a converter downstream only needs to latch on that strobe.

Bytes from a keyboard front end arrive as scan codes with a one-cycle valid strobe. The four arrow keys nudge the waveform. Up and down move the amplitude by one step. Right and left shorten or lengthen the half-period by a fixed step. A held key event is consumed once per period, at the moment the high half ends, so a period never changes shape midway. The current amplitude and half-period are also presented on output ports.

Top module: `sqkg_top`

## Requirements
- R1: After a synchronous reset the output code is 0, the write strobe is low, the amplitude is all ones (0xFFF), the half-period is HALF_INIT (0xFF by default), and the waveform begins with its low half.
- R2: Each half lasts exactly half_ticks clock cycles. The code is 0 in the low half and amp_level in the high half. dac_wr is high for one cycle in the cycle the new code first appears, and at no other time.
- R3: Only bits [7:0] of key_code are decoded; the upper bits are ignored.
- R4: Code 0x75 raises the amplitude by 1, and code 0x72 lowers it by 1.
- R5: Code 0x74 reduces the half-period by 5 ticks (higher frequency), and code 0x6B increases it by 5 ticks.
- R6: Any other low byte leaves amplitude and half-period unchanged, and the waveform continues without a break.
- R7: The held key event is applied on the clock edge that ends a high half. amp_level and half_ticks change only on that edge, and the new values govern the period that starts there.
- R8: The amplitude saturates at 0x000 and 0xFFF and never wraps.
- R9: The half-period stays between 5 and HALF_MAX (0xFFF by default); steps that would leave that range stop at the bound.
- R10: One key event is held per period. A later valid code replaces an earlier unapplied one, including an unrecognised code, which replaces it with no action. A code that arrives on the applying edge is kept for the following period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | Strobe qualifying key_code for one cycle |
| key_code | input | KEY_W (16) | Scan code; only the low byte is decoded |
| dac_code | output | DAC_W (12) | Registered converter code |
| dac_wr | output | 1 | One-cycle strobe at each level change |
| amp_level | output | DAC_W (12) | Current high-level amplitude |
| half_ticks | output | CNT_W (12) | Current half-period in clock ticks |

## Verification
The bench builds the block with HALF_INIT set to 12 and HALF_MAX set to 40, and leaves the other parameters at their defaults. The short half-period keeps each period to a few dozen cycles. This makes it affordable to step the amplitude through all 4096 codes down to its floor, and to drive the half-period into both of its clamps. The low HALF_MAX lets the upper half-period clamp be reached in a handful of key presses. Key events are placed both mid-period and in pairs within one period, so that the replacement rule and the edge-aligned update are observed against a cycle-level reference model.

// File: rtl/sqkg_pkg.sv
package sqkg_pkg;
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_AMP_UP = 3'd1,
    ACT_AMP_DN = 3'd2,
    ACT_FASTER = 3'd3,
    ACT_SLOWER = 3'd4
  } key_act_t;
endpackage

// File: rtl/sqkg_key_slot.sv
module sqkg_key_slot
  import sqkg_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [7:0] CODE_UP    = 8'h75,
  parameter logic [7:0] CODE_DOWN  = 8'h72,
  parameter logic [7:0] CODE_RIGHT = 8'h74,
  parameter logic [7:0] CODE_LEFT  = 8'h6B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_code,
  input  logic             take,
  output key_act_t         act
);
  logic [7:0] low_byte;

  generate
    if (KEY_W >= 8) begin : g_wide
      assign low_byte = key_code[7:0];
    end else begin : g_narrow
      assign low_byte = {{(8-KEY_W){1'b0}}, key_code};
    end
  endgenerate

  key_act_t decoded;
  always_comb begin
    if      (low_byte == CODE_UP)    decoded = ACT_AMP_UP;
    else if (low_byte == CODE_DOWN)  decoded = ACT_AMP_DN;
    else if (low_byte == CODE_RIGHT) decoded = ACT_FASTER;
    else if (low_byte == CODE_LEFT)  decoded = ACT_SLOWER;
    else                             decoded = ACT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)            act <= ACT_NONE;
    else if (key_valid) act <= decoded;
    else if (take)      act <= ACT_NONE;
  end

  assert_slot_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (take && !key_valid) |=> (act == ACT_NONE));
  assert_slot_load_R10: assert property (@(posedge clk) disable iff (rst)
    (key_valid && low_byte == CODE_UP) |=> (act == ACT_AMP_UP));
endmodule

// File: rtl/sqkg_settings.sv
module sqkg_settings
  import sqkg_pkg::*;
#(
  parameter int DAC_W     = 12,
  parameter int CNT_W     = 12,
  parameter int AMP_INIT  = 4095,
  parameter int HALF_INIT = 255,
  parameter int HALF_STEP = 5,
  parameter int HALF_MIN  = 5,
  parameter int HALF_MAX  = 4095
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  key_act_t         act,
  output logic [DAC_W-1:0] amp,
  output logic [CNT_W-1:0] half
);
  localparam logic [DAC_W-1:0] AMP_TOP  = {DAC_W{1'b1}};
  localparam logic [CNT_W:0]   STEP_W   = (CNT_W+1)'(HALF_STEP);
  localparam logic [CNT_W:0]   MIN_W    = (CNT_W+1)'(HALF_MIN);
  localparam logic [CNT_W:0]   MAX_W    = (CNT_W+1)'(HALF_MAX);

  logic [CNT_W:0]   half_ext, half_up, half_dn;
  logic [DAC_W-1:0] amp_nx;
  logic [CNT_W-1:0] half_nx;

  assign half_ext = {1'b0, half};
  assign half_up  = half_ext + STEP_W;
  assign half_dn  = half_ext - STEP_W;

  always_comb begin
    amp_nx  = amp;
    half_nx = half;
    unique case (act)
      ACT_AMP_UP: if (amp != AMP_TOP) amp_nx = amp + 1'b1;
      ACT_AMP_DN: if (amp != '0)      amp_nx = amp - 1'b1;
      ACT_FASTER: half_nx = (half_ext < MIN_W + STEP_W) ? MIN_W[CNT_W-1:0] : half_dn[CNT_W-1:0];
      ACT_SLOWER: half_nx = (half_up > MAX_W) ? MAX_W[CNT_W-1:0] : half_up[CNT_W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp  <= DAC_W'(AMP_INIT);
      half <= CNT_W'(HALF_INIT);
    end else if (take) begin
      amp  <= amp_nx;
      half <= half_nx;
    end
  end

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(amp) && $stable(half)));
  assert_half_range_R9: assert property (@(posedge clk) disable iff (rst)
    (half >= CNT_W'(HALF_MIN)) && ({1'b0, half} <= MAX_W));
  assert_amp_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(amp) |-> (amp == $past(amp) + 1'b1 || amp == $past(amp) - 1'b1));
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(amp) == AMP_TOP && amp != AMP_TOP) |-> amp == AMP_TOP - 1'b1);
endmodule

// File: rtl/sqkg_phase.sv
module sqkg_phase #(
  parameter int DAC_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DAC_W-1:0] amp,
  input  logic [CNT_W-1:0] half,
  output logic             take,
  output logic [DAC_W-1:0] code,
  output logic             wr
);
  logic             high;
  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  assign last_tick = (cnt == half - 1'b1);
  assign take      = last_tick && high;

  always_ff @(posedge clk) begin
    if (rst) begin
      high <= 1'b0;
      cnt  <= '0;
      code <= '0;
      wr   <= 1'b0;
    end else if (last_tick) begin
      high <= !high;
      cnt  <= '0;
      code <= high ? '0 : amp;
      wr   <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      wr   <= 1'b0;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < half);
  assert_wr_single_R2: assert property (@(posedge clk) disable iff (rst)
    wr |=> !wr);
endmodule

// File: rtl/sqkg_top.sv
module sqkg_top
  import sqkg_pkg::*;
#(
  parameter int DAC_W     = 12,
  parameter int CNT_W     = 12,
  parameter int KEY_W     = 16,
  parameter int AMP_INIT  = 4095,
  parameter int HALF_INIT = 255,
  parameter int HALF_STEP = 5,
  parameter int HALF_MIN  = 5,
  parameter int HALF_MAX  = 4095
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_code,
  output logic [DAC_W-1:0] dac_code,
  output logic             dac_wr,
  output logic [DAC_W-1:0] amp_level,
  output logic [CNT_W-1:0] half_ticks
);
  key_act_t act;
  logic     take;

  sqkg_key_slot #(.KEY_W(KEY_W)) u_slot (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
    .take(take), .act(act)
  );

  sqkg_settings #(
    .DAC_W(DAC_W), .CNT_W(CNT_W), .AMP_INIT(AMP_INIT), .HALF_INIT(HALF_INIT),
    .HALF_STEP(HALF_STEP), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)
  ) u_set (
    .clk(clk), .rst(rst), .take(take), .act(act),
    .amp(amp_level), .half(half_ticks)
  );

  sqkg_phase #(.DAC_W(DAC_W), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .amp(amp_level), .half(half_ticks),
    .take(take), .code(dac_code), .wr(dac_wr)
  );

  assert_wr_on_change_R2: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code)) |-> dac_wr);
endmodule

// File: tb/sqkg_top_test.sv
module sqkg_top_test;
  localparam int HI = 12;
  localparam int HM = 40;

  logic        clk = 0;
  logic        rst = 1;
  logic        key_valid = 0;
  logic [15:0] key_code = 0;
  logic [11:0] dac_code, amp_level, half_ticks;
  logic        dac_wr;

  always #5 clk = ~clk;

  sqkg_top #(.HALF_INIT(HI), .HALF_MAX(HM)) uut (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
    .dac_code(dac_code), .dac_wr(dac_wr), .amp_level(amp_level), .half_ticks(half_ticks)
  );

  int errs = 0, checks = 0, cycles = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_high, m_cnt, m_amp, m_half, m_pend, m_dac, m_wr, m_takes;

  function automatic int decode(input int c);
    case (c & 255)
      'h75: return 1;
      'h72: return 2;
      'h74: return 3;
      'h6B: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_high = 0; m_cnt = 0; m_amp = 4095; m_half = HI; m_pend = 0;
      m_dac = 0; m_wr = 0; m_takes = 0;
    end else begin
      int act, endh, samp;
      act  = m_pend;
      endh = (m_cnt == m_half - 1);
      samp = endh && m_high;
      if (endh) begin
        m_high = !m_high; m_cnt = 0; m_wr = 1;
        m_dac = m_high ? m_amp : 0;
      end else begin
        m_cnt++; m_wr = 0;
      end
      if (samp) begin
        m_takes++;
        if (act == 1 && m_amp < 4095) m_amp++;
        if (act == 2 && m_amp > 0) m_amp--;
        if (act == 3) m_half = (m_half - 5 < 5) ? 5 : m_half - 5;
        if (act == 4) m_half = (m_half + 5 > HM) ? HM : m_half + 5;
      end
      if (key_valid) m_pend = decode(key_code);
      else if (samp) m_pend = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 dac_code", dac_code, m_dac);
      chk("R2 dac_wr", dac_wr, m_wr);
      chk("R7 amp_level", amp_level, m_amp);
      chk("R7 half_ticks", half_ticks, m_half);
    end
  end

  always @(posedge clk) begin
    if (cycles == 190000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic hit(input int code);
    @(negedge clk);
    key_valid = 1; key_code = code[15:0];
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic wait_take();
    int t0 = m_takes;
    while (m_takes == t0) @(negedge clk);
  endtask

  task automatic press(input int code);
    hit(code);
    wait_take();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset dac", dac_code, 0);
    chk("R1 reset wr", dac_wr, 0);
    chk("R1 reset amp", amp_level, 4095);
    chk("R1 reset half", half_ticks, HI);
    rst = 0;
    // low half first: code stays 0 for HI cycles
    repeat (HI - 1) @(negedge clk);
    chk("R1 low first", dac_code, 0);
    @(negedge clk);
    chk("R2 rises after half", dac_code, 4095);
    chk("R2 strobe at rise", dac_wr, 1);
    begin
      int n = 0;
      @(negedge clk);
      while (!dac_wr) begin n++; @(negedge clk); end
      chk("R2 high half length", n + 1, HI);
      chk("R2 falls to zero", dac_code, 0);
    end
    // R3: upper bits ignored
    press('h1F72);
    chk("R3 masked down", amp_level, 4094);
    @(negedge clk);
    while (!dac_wr) @(negedge clk);
    chk("R7 new amp in next high", dac_code, 4094);
    press('h75);
    chk("R4 up", amp_level, 4095);
    press('h75);
    chk("R8 top saturate", amp_level, 4095);
    press('h72);
    chk("R4 down", amp_level, 4094);
    press('h6B);
    chk("R5 left lengthens", half_ticks, HI + 5);
    for (int i = 0; i < 6; i++) press('h6B);
    chk("R9 upper clamp", half_ticks, HM);
    press('h74);
    chk("R5 right shortens", half_ticks, HM - 5);
    press('h12);
    chk("R6 other code amp", amp_level, 4094);
    chk("R6 other code half", half_ticks, HM - 5);
    // R10: two codes in one period, last wins
    hit('h6B);
    hit('h74);
    wait_take();
    chk("R10 last code wins", half_ticks, HM - 10);
    hit('h74);
    hit('h33);
    wait_take();
    chk("R10 unknown replaces", half_ticks, HM - 10);
    for (int i = 0; i < 8; i++) press('h74);
    chk("R9 lower clamp", half_ticks, 5);
    for (int i = 0; i < 4100; i++) press('h72);
    chk("R8 floor saturate", amp_level, 0);
    repeat (30) @(negedge clk);
    chk("R2 zero amp code", dac_code, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule